// File: doc/BRIEF.md
# Huffman Codeword Backtracker

This block turns a finished Huffman tree into per-symbol codewords. The tree is supplied as a flat table of packed node words. Each word carries four fields: the node's own identifier, the identifier of its parent, the branch bit that leads from the parent to this node, and a symbol value. A list of symbols is supplied alongside the table. After a start pulse, the block takes each symbol in turn and looks for its leaf. It then climbs parent links toward the root and gathers one branch bit per level. The bits gathered form the codeword, and their count is the code length.

The engine is a small clocked state machine that inspects one table entry per cycle. Results are written into per-symbol output registers, and `done` goes high when the whole list has been handled. The table, the counts and the symbol list are expected to stay stable from the start pulse until `done`.

Top module: `huff_code_walker`

## Requirements
- R1: A node word is {parent id [23:16], branch bit [15], own id [14:7], symbol [6:0]}. A symbol's leaf is the lowest-index entry, among the first node_cnt entries, whose bits [6:0] equal the symbol.
- R2: The parent of the current node is the lowest-index entry, among the first node_cnt, whose own id equals the current node's parent id. Each climb writes the current node's branch bit at codeword bit position len and then increments len. Bit 0 is the bit nearest the leaf.
- R3: A climb that reaches a parent whose parent id field is zero appends its bit and then ends the walk. That parent is the root.
- R4: If no entry matches the current parent id, the walk ends and the bits already gathered are kept as the result.
- R5: A walk ends once 4 bits have been gathered, even if the root has not been reached. len never exceeds 4.
- R6: A symbol with no matching leaf gets codeword 0 and length 0.
- R7: Codeword bits at positions len and above are zero. A start pulse clears every result slot, so slots not written in a run read zero.
- R8: Symbols are handled in index order, and only the first sym_cnt are handled. sym_cnt values above 4 are treated as 4, and node_cnt values above 7 are treated as 7. With sym_cnt = 0, done rises one cycle after start and all results are zero.
- R9: done is 0 after reset. It is 0 in the cycle after an accepted start (when sym_cnt is not 0) and rises once all symbols are handled. It then stays high with stable outputs until the next start. A start while a run is in progress is ignored.
- R10: Symbol i's codeword is code_o[4i+3:4i] and its length is len_o[4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; ignored while busy |
| node_tbl | input | 168 | Seven packed 24-bit node words, entry i at bits [24i+23:24i] |
| node_cnt | input | 4 | Number of valid table entries |
| sym_list | input | 28 | Four 7-bit symbols, symbol i at bits [7i+6:7i] |
| sym_cnt | input | 3 | Number of symbols to process |
| code_o | output | 16 | Four 4-bit codewords |
| len_o | output | 16 | Four 4-bit code lengths |
| done | output | 1 | High when a run has completed |

## Verification
The assertions assume that the table, both counts and the symbol list stay stable from an accepted start until done. They also assume that start is not asserted in the same cycle as reset. The stimulus changes these inputs only at a falling edge just before a start pulse, and holds them until done is seen. The one exception is an extra start pulse during a run, which checks that the block ignores it. Tables include a well-formed tree, a chain deeper than the length cap, a table truncated by node_cnt so that the root is out of reach, and an empty table.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  localparam int NODE_W  = 24;
  localparam int ID_W    = 8;
  localparam int SYM_W   = 7;
  localparam int PAR_LSB = 16;
  localparam int BIT_POS = 15;
  localparam int ID_LSB  = 7;
  localparam int SYM_LSB = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAF,
    S_UP,
    S_STORE,
    S_DONE
  } hbt_state_e;
endpackage

// File: rtl/hbt_slot_sel.sv
module hbt_slot_sel #(
  parameter int N     = 7,
  parameter int W     = 24,
  parameter int IDX_W = 4
) (
  input  logic [N*W-1:0]   flat,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     word
);
  logic [W-1:0] slots [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_unpack
      assign slots[g] = flat[g*W +: W];
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) word = slots[i];
    end
  end
endmodule

// File: rtl/hbt_code_accum.sv
module hbt_code_accum #(
  parameter int CODE_W = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              push_bit,
  output logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
      len  <= '0;
    end else if (push) begin
      code <= code | (CODE_W'(push_bit) << len);
      len  <= len + LEN_W'(1);
    end
  end

  p_len_cap_r5: assert property (@(posedge clk) disable iff (rst)
    len <= LEN_W'(CODE_W));

  p_no_push_full_r5: assert property (@(posedge clk) disable iff (rst)
    push |-> len < LEN_W'(CODE_W));

  p_upper_bits_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (code >> len) == '0);

  p_append_r2: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> (len == $past(len) + LEN_W'(1)) &&
      (code == ($past(code) | (CODE_W'($past(push_bit)) << $past(len)))));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (code == '0) && (len == '0));
endmodule

// File: rtl/hbt_result_bank.sv
module hbt_result_bank #(
  parameter int SYMS   = 4,
  parameter int CODE_W = 4,
  parameter int LEN_W  = 4,
  parameter int SIDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_all,
  input  logic                    wr,
  input  logic [SIDX_W-1:0]       wr_idx,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic [LEN_W-1:0]        wr_len,
  output logic [SYMS*CODE_W-1:0]  code_flat,
  output logic [SYMS*LEN_W-1:0]   len_flat
);
  genvar g;
  generate
    for (g = 0; g < SYMS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst || clr_all) begin
          code_flat[g*CODE_W +: CODE_W] <= '0;
          len_flat[g*LEN_W +: LEN_W]    <= '0;
        end else if (wr && wr_idx == SIDX_W'(g)) begin
          code_flat[g*CODE_W +: CODE_W] <= wr_code;
          len_flat[g*LEN_W +: LEN_W]    <= wr_len;
        end
      end
    end
  endgenerate

  p_wr_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    wr |-> wr_idx < SIDX_W'(SYMS));

  p_wr_len_cap_r5: assert property (@(posedge clk) disable iff (rst)
    wr |-> wr_len <= LEN_W'(CODE_W));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (code_flat == '0) && (len_flat == '0));
endmodule

// File: rtl/huff_code_walker.sv
module huff_code_walker
  import hbt_pkg::*;
#(
  parameter int NODES  = 7,
  parameter int SYMS   = 4,
  parameter int CODE_W = 4,
  localparam int NIDX_W = $clog2(NODES) + 1,
  localparam int SIDX_W = $clog2(SYMS) + 1,
  localparam int LEN_W  = CODE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NODES*NODE_W-1:0]   node_tbl,
  input  logic [NIDX_W-1:0]         node_cnt,
  input  logic [SYMS*SYM_W-1:0]     sym_list,
  input  logic [SIDX_W-1:0]         sym_cnt,
  output logic [SYMS*CODE_W-1:0]    code_o,
  output logic [SYMS*LEN_W-1:0]     len_o,
  output logic                      done
);
  hbt_state_e        state;
  logic [NIDX_W-1:0] node_idx;
  logic [SIDX_W-1:0] sym_idx;
  logic [ID_W-1:0]   cur_par;
  logic              cur_bit;
  logic              done_r;

  logic [NODE_W-1:0] rd_word;
  logic [SYM_W-1:0]  want_sym;
  logic [NIDX_W-1:0] eff_ncnt;
  logic [SIDX_W-1:0] eff_scnt;
  logic [CODE_W-1:0] acc_code;
  logic [LEN_W-1:0]  acc_len;
  logic busy, go, in_range, leaf_hit, par_hit, at_root, at_limit;
  logic acc_clr, acc_push, bank_wr, last_sym;

  assign eff_ncnt = (node_cnt > NIDX_W'(NODES)) ? NIDX_W'(NODES) : node_cnt;
  assign eff_scnt = (sym_cnt > SIDX_W'(SYMS)) ? SIDX_W'(SYMS) : sym_cnt;

  hbt_slot_sel #(.N(NODES), .W(NODE_W), .IDX_W(NIDX_W)) u_node_rd (
    .flat(node_tbl), .idx(node_idx), .word(rd_word));

  hbt_slot_sel #(.N(SYMS), .W(SYM_W), .IDX_W(SIDX_W)) u_sym_rd (
    .flat(sym_list), .idx(sym_idx), .word(want_sym));

  assign busy     = (state == S_LEAF) || (state == S_UP) || (state == S_STORE);
  assign go       = start && !busy;
  assign in_range = node_idx < eff_ncnt;
  assign leaf_hit = rd_word[SYM_LSB +: SYM_W] == want_sym;
  assign par_hit  = rd_word[ID_LSB +: ID_W] == cur_par;
  assign at_root  = rd_word[PAR_LSB +: ID_W] == '0;
  assign at_limit = acc_len == LEN_W'(CODE_W - 1);
  assign last_sym = (sym_idx + SIDX_W'(1)) == eff_scnt;

  assign acc_clr  = go || (state == S_STORE);
  assign acc_push = (state == S_UP) && in_range && par_hit;
  assign bank_wr  = (state == S_STORE);

  hbt_code_accum #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_accum (
    .clk(clk), .rst(rst), .clr(acc_clr), .push(acc_push),
    .push_bit(cur_bit), .code(acc_code), .len(acc_len));

  hbt_result_bank #(.SYMS(SYMS), .CODE_W(CODE_W), .LEN_W(LEN_W),
                    .SIDX_W(SIDX_W)) u_bank (
    .clk(clk), .rst(rst), .clr_all(go), .wr(bank_wr), .wr_idx(sym_idx),
    .wr_code(acc_code), .wr_len(acc_len), .code_flat(code_o), .len_flat(len_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      node_idx <= '0;
      sym_idx  <= '0;
      cur_par  <= '0;
      cur_bit  <= 1'b0;
      done_r   <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            node_idx <= '0;
            sym_idx  <= '0;
            if (eff_scnt == '0) begin
              state  <= S_DONE;
              done_r <= 1'b1;
            end else begin
              state  <= S_LEAF;
              done_r <= 1'b0;
            end
          end
        end
        S_LEAF: begin
          if (!in_range) begin
            state <= S_STORE;
          end else if (leaf_hit) begin
            cur_par  <= rd_word[PAR_LSB +: ID_W];
            cur_bit  <= rd_word[BIT_POS];
            node_idx <= '0;
            state    <= S_UP;
          end else begin
            node_idx <= node_idx + NIDX_W'(1);
          end
        end
        S_UP: begin
          if (!in_range) begin
            state <= S_STORE;
          end else if (par_hit) begin
            if (at_root || at_limit) begin
              state <= S_STORE;
            end else begin
              cur_par  <= rd_word[PAR_LSB +: ID_W];
              cur_bit  <= rd_word[BIT_POS];
              node_idx <= '0;
            end
          end else begin
            node_idx <= node_idx + NIDX_W'(1);
          end
        end
        S_STORE: begin
          node_idx <= '0;
          if (last_sym) begin
            state  <= S_DONE;
            done_r <= 1'b1;
          end else begin
            sym_idx <= sym_idx + SIDX_W'(1);
            state   <= S_LEAF;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done = done_r;

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && $stable(code_o) && $stable(len_o));

  p_start_drops_done_r9: assert property (@(posedge clk) disable iff (rst)
    (go && eff_scnt != '0) |=> !done);

  p_empty_list_r8: assert property (@(posedge clk) disable iff (rst)
    (go && eff_scnt == '0) |=> done && (code_o == '0) && (len_o == '0));

  p_busy_not_done_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
endmodule

// File: tb/huff_code_walker_bench.sv
module huff_code_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [167:0]  node_tbl = '0;
  logic [3:0]    node_cnt = '0;
  logic [27:0]   sym_list = '0;
  logic [2:0]    sym_cnt = '0;
  logic [15:0]   code_o;
  logic [15:0]   len_o;
  logic          done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  huff_code_walker u_huff_code_walker (
    .clk(clk), .rst(rst), .start(start), .node_tbl(node_tbl),
    .node_cnt(node_cnt), .sym_list(sym_list), .sym_cnt(sym_cnt),
    .code_o(code_o), .len_o(len_o), .done(done));

  function automatic logic [23:0] mk(logic [7:0] p, logic b, logic [7:0] id, logic [6:0] s);
    return {p, b, id, s};
  endfunction

  // Balanced tree: root id FF; symbols 61,62,63,64 at entries 0,3,1,5
  localparam logic [167:0] T0 = {
    mk(8'h00, 1'b0, 8'hFF, 7'h7F), mk(8'hFF, 1'b0, 8'h06, 7'h64),
    mk(8'hFF, 1'b1, 8'h05, 7'h7F), mk(8'h05, 1'b0, 8'h04, 7'h62),
    mk(8'h05, 1'b1, 8'h03, 7'h7F), mk(8'h03, 1'b1, 8'h02, 7'h63),
    mk(8'h03, 1'b0, 8'h01, 7'h61)};

  // Chain deeper than the length cap; entry 6 is filler outside node_cnt
  localparam logic [167:0] T1 = {
    24'h000000,                    mk(8'h00, 1'b0, 8'h06, 7'h7F),
    mk(8'h06, 1'b0, 8'h05, 7'h20), mk(8'h05, 1'b1, 8'h04, 7'h7F),
    mk(8'h04, 1'b1, 8'h03, 7'h7F), mk(8'h03, 1'b0, 8'h02, 7'h7F),
    mk(8'h02, 1'b1, 8'h01, 7'h10)};

  typedef struct packed {
    logic [167:0] tbl;
    logic [3:0]   nc;
    logic [27:0]  syms;
    logic [2:0]   sc;
    logic [15:0]  ecode;
    logic [15:0]  elen;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{T0, 4'd7,  {7'h64, 7'h63, 7'h62, 7'h61}, 3'd4, 16'h0726, 16'h1323},
    '{T0, 4'd7,  {7'h61, 7'h00, 7'h62, 7'h64}, 3'd4, 16'h6020, 16'h3021},
    '{T0, 4'd7,  {7'h64, 7'h62, 7'h61, 7'h63}, 3'd2, 16'h0067, 16'h0033},
    '{T1, 4'd6,  {7'h00, 7'h00, 7'h20, 7'h10}, 3'd2, 16'h000D, 16'h0014},
    '{T0, 4'd5,  {7'h00, 7'h61, 7'h62, 7'h64}, 3'd3, 16'h0200, 16'h0210},
    '{T0, 4'd12, {7'h64, 7'h63, 7'h62, 7'h61}, 3'd7, 16'h0726, 16'h1323},
    '{T0, 4'd7,  {7'h64, 7'h63, 7'h62, 7'h61}, 3'd0, 16'h0000, 16'h0000},
    '{T0, 4'd0,  {7'h64, 7'h63, 7'h62, 7'h61}, 3'd4, 16'h0000, 16'h0000}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1 R2 R3 R10 tree";
      1: return "R6 R8 order with missing symbol";
      2: return "R7 R8 partial list";
      3: return "R5 length cap";
      4: return "R4 root out of reach";
      5: return "R8 count clamp";
      6: return "R8 empty list";
      default: return "R6 empty table";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i, input bit extra_start);
    vec_t v;
    v = VEC[i];
    @(negedge clk);
    node_tbl = v.tbl;
    node_cnt = v.nc;
    sym_list = v.syms;
    sym_cnt  = v.sc;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == (v.sc == 3'd0), {"R9 done after start ", vtag(i)},
        16'(done), 16'(v.sc == 3'd0));
    for (int c = 0; c < 1000 && !done; c++) begin
      start = extra_start && (c == 2);
      @(negedge clk);
    end
    start = 1'b0;
    chk(done, {"R9 completion ", vtag(i)}, 16'(done), 16'h1);
    chk(code_o == v.ecode, {"codeword ", vtag(i)}, code_o, v.ecode);
    chk(len_o == v.elen, {"length ", vtag(i)}, len_o, v.elen);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held_code;
    logic [15:0] held_len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: R9 done low, R7 results zero
    chk(done == 1'b0, "R9 reset done", 16'(done), 16'h0);
    chk(code_o == '0, "R7 reset codes", code_o, 16'h0);
    chk(len_o == '0, "R7 reset lengths", len_o, 16'h0);

    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

    // R9: results and done hold until the next start
    run_vec(0, 1'b0);
    held_code = code_o;
    held_len  = len_o;
    repeat (6) @(negedge clk);
    chk(done, "R9 done held", 16'(done), 16'h1);
    chk(code_o == held_code && len_o == held_len, "R9 outputs held",
        code_o, held_code);

    // R9: start during a run is ignored
    run_vec(1, 1'b1);

    // R7: restart after a full run clears unused slots
    run_vec(0, 1'b0);
    run_vec(2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule